// File: doc/BRIEF.md
# Two-Level Lookahead Binary Adder

This block adds two 16-bit operands and a carry-in in a single combinational step. It does not use a ripple chain or one flat lookahead equation. It splits the operands into four 4-bit groups. Each group reduces its per-bit generate (`a AND b`) and propagate (`a XOR b`) terms into one group generate and one group propagate. Inside the group, the terms are combined in pairs first and the two pairs are then merged.

A second-level lookahead unit takes the four group pairs and the external carry-in. From them it produces the carry into every group and the final carry-out. Each group then expands its internal carries from its own carry-in and forms its sum bits. The whole-word generate and propagate are also brought out, so a wider adder can place this block under a further lookahead level.

Top module: `cla_adder`

## Requirements
- R1: `sum` equals `(opa + opb + carry_in) mod 2^16` for every input combination.
- R2: `carry_out` equals bit 16 of the 17-bit result `opa + opb + carry_in`.
- R3: `blk_gen` is 1 exactly when `opa + opb` alone exceeds `0xFFFF`, whatever the value of `carry_in`.
- R4: `blk_prop` is 1 exactly when `opa XOR opb` equals `0xFFFF`, meaning every bit position propagates.
- R5: `carry_out` always equals `blk_gen OR (blk_prop AND carry_in)`.
- R6: When every bit propagates and `carry_in` is 1, the carry crosses all four groups: `sum` is `0x0000` and `carry_out` is 1 (for example `0xAAAA + 0x5555 + 1` and `0xFFFF + 0x0000 + 1`).
- R7: A carry generated in a lower group reaches the next group through the second-level unit. `0x000F+1`, `0x00FF+1` and `0x0FFF+1` give `0x0010`, `0x0100` and `0x1000`.
- R8: `blk_gen` and `blk_prop` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | 16 | First operand |
| opb | input | 16 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | 16 | Sum bits |
| carry_out | output | 1 | Carry out of bit 15 |
| blk_gen | output | 1 | Whole-word generate |
| blk_prop | output | 1 | Whole-word propagate |

## Verification
Two functions can act in the same evaluation: the external carry-in passing through every group by propagation, and a carry generated inside one group. A wrong priority between them corrupts both the sum and `carry_out`. The bench provokes each case on its own. Full-propagate operands with `carry_in` high exercise the pure pass-through, and `0xFFFF + 0xFFFF + 1` makes a generated carry and the carry-in meet. Each result is judged against a behavioural 17-bit sum and against the `blk_gen`/`blk_prop` relation.

// File: rtl/cla_pkg.sv
package cla_pkg;
   // Generate/propagate pair shared by every lookahead level.
   typedef struct packed {
      logic gen;
      logic prop;
   } gp_t;
endpackage

// File: rtl/cla_gp_tree.sv
// Reduces N generate/propagate pairs to one, pairing neighbours first.
module cla_gp_tree #(
   parameter int N = 4
) (
   input  cla_pkg::gp_t [N-1:0] leaf,
   output cla_pkg::gp_t         root
);
   if (N < 2 || (N & (N - 1)) != 0) begin : g_bad_n
      $error("cla_gp_tree: N must be a power of two, at least 2");
   end

   cla_pkg::gp_t node [N];

   always_comb begin
      for (int i = 0; i < N; i++) node[i] = leaf[i];
      for (int s = 1; s < N; s = s * 2) begin
         for (int i = 0; i + 2 * s <= N; i = i + 2 * s) begin
            node[i+2*s-1].gen  = node[i+2*s-1].gen
                               | (node[i+2*s-1].prop & node[i+s-1].gen);
            node[i+2*s-1].prop = node[i+2*s-1].prop & node[i+s-1].prop;
         end
      end
      root = node[N-1];
   end

   // R8: a reduced span cannot both generate and propagate
   always_comb begin
      a_r8_tree_excl: assert (!(root.gen && root.prop))
         else $error("tree root generates and propagates");
   end
endmodule

// File: rtl/cla_lookahead.sv
// Fully expanded carries: carry[i] is the carry into position i, carry[N] leaves.
module cla_lookahead #(
   parameter int N = 4
) (
   input  cla_pkg::gp_t [N-1:0] gp,
   input  logic                 cin,
   output logic [N:0]           carry
);
   if (N < 1) begin : g_bad_n
      $error("cla_lookahead: N must be at least 1");
   end

   always_comb begin
      for (int i = 0; i <= N; i++) begin
         logic acc;
         logic term;
         term = cin;
         for (int k = 0; k < i; k++) term = term & gp[k].prop;
         acc = term;
         for (int j = 0; j < i; j++) begin
            term = gp[j].gen;
            for (int k = j + 1; k < i; k++) term = term & gp[k].prop;
            acc = acc | term;
         end
         carry[i] = acc;
      end
   end

   // R2: the expanded carries agree with the one-step recurrence
   always_comb begin
      a_r2_base: assert (carry[0] == cin) else $error("carry[0] differs from cin");
      for (int i = 0; i < N; i++) begin
         a_r2_step: assert (carry[i+1] == (gp[i].gen | (gp[i].prop & carry[i])))
            else $error("carry step mismatch at %0d", i);
      end
   end
endmodule

// File: rtl/cla_group.sv
// One lookahead group: per-bit terms, internal carries, sums, group pair.
module cla_group #(
   parameter int W = 4
) (
   input  logic [W-1:0]  a,
   input  logic [W-1:0]  b,
   input  logic          cin,
   output logic [W-1:0]  sum,
   output cla_pkg::gp_t  grp
);
   cla_pkg::gp_t [W-1:0] bit_gp;
   logic [W-1:0]         bit_p;
   logic [W:0]           c;

   for (genvar i = 0; i < W; i++) begin : g_bit
      assign bit_gp[i].gen  = a[i] & b[i];
      assign bit_gp[i].prop = a[i] ^ b[i];
      assign bit_p[i]       = bit_gp[i].prop;
   end

   cla_lookahead #(.N(W)) u_carry (
      .gp    (bit_gp),
      .cin   (cin),
      .carry (c)
   );

   cla_gp_tree #(.N(W)) u_tree (
      .leaf (bit_gp),
      .root (grp)
   );

   assign sum = bit_p ^ c[W-1:0];

   // R5: expanded group carry-out matches the reduced group pair
   always_comb begin
      a_r5_grp_cout: assert (c[W] == (grp.gen | (grp.prop & cin)))
         else $error("group carry-out disagrees with group pair");
   end
endmodule

// File: rtl/cla_adder.sv
// Two-level lookahead adder: groups feed one second-level carry unit.
module cla_adder #(
   parameter int WIDTH = 16,
   parameter int GROUP = 4
) (
   input  logic [15:0] opa,
   input  logic [15:0] opb,
   input  logic        carry_in,
   output logic [15:0] sum,
   output logic        carry_out,
   output logic        blk_gen,
   output logic        blk_prop
);
   localparam int NGRP = WIDTH / GROUP;
   localparam int XW   = WIDTH + 1;

   if (WIDTH != 16) begin : g_bad_width
      $error("cla_adder: port widths are fixed at 16 bits");
   end
   if (GROUP < 2 || (WIDTH % GROUP) != 0) begin : g_bad_group
      $error("cla_adder: GROUP must divide WIDTH");
   end
   if ((NGRP & (NGRP - 1)) != 0) begin : g_bad_ngrp
      $error("cla_adder: group count must be a power of two");
   end

   cla_pkg::gp_t [NGRP-1:0] grp_gp;
   logic [NGRP:0]           gcarry;
   cla_pkg::gp_t            word_gp;

   for (genvar k = 0; k < NGRP; k++) begin : g_grp
      cla_group #(.W(GROUP)) u_grp (
         .a   (opa[k*GROUP +: GROUP]),
         .b   (opb[k*GROUP +: GROUP]),
         .cin (gcarry[k]),
         .sum (sum[k*GROUP +: GROUP]),
         .grp (grp_gp[k])
      );
   end

   cla_lookahead #(.N(NGRP)) u_lvl2 (
      .gp    (grp_gp),
      .cin   (carry_in),
      .carry (gcarry)
   );

   cla_gp_tree #(.N(NGRP)) u_word (
      .leaf (grp_gp),
      .root (word_gp)
   );

   assign carry_out = gcarry[NGRP];
   assign blk_gen   = word_gp.gen;
   assign blk_prop  = word_gp.prop;

   logic [WIDTH:0] ref_full;
   logic [WIDTH:0] ref_nocin;
   always_comb begin
      ref_full  = {1'b0, opa} + {1'b0, opb} + XW'(carry_in);
      ref_nocin = {1'b0, opa} + {1'b0, opb};
      a_r1_sum: assert (sum == ref_full[WIDTH-1:0]) else $error("sum mismatch");
      a_r2_cout: assert (carry_out == ref_full[WIDTH]) else $error("carry-out mismatch");
      a_r3_gen: assert (blk_gen == ref_nocin[WIDTH]) else $error("word generate mismatch");
      a_r4_prop: assert (blk_prop == &(opa ^ opb)) else $error("word propagate mismatch");
      a_r5_cout_rel: assert (carry_out == (blk_gen | (blk_prop & carry_in)))
         else $error("carry-out disagrees with word pair");
      a_r8_excl: assert (!(blk_gen && blk_prop)) else $error("generate and propagate both set");
   end
endmodule

// File: tb/cla_adder_tb.sv
module cla_adder_tb;
   logic        clk = 1'b0;
   logic [15:0] opa, opb;
   logic        carry_in;
   logic [15:0] sum;
   logic        carry_out, blk_gen, blk_prop;
   int          nchk = 0;
   int          nfail = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;  // 200 MHz

   cla_adder u_dut (
      .opa       (opa),
      .opb       (opb),
      .carry_in  (carry_in),
      .sum       (sum),
      .carry_out (carry_out),
      .blk_gen   (blk_gen),
      .blk_prop  (blk_prop)
   );

   // Row layout: {a, b, cin, sum, cout, gen, prop}
   localparam int NV = 12;
   localparam logic [51:0] VECS [NV] = '{
      {16'h0000, 16'hFFFF, 1'b0, 16'hFFFF, 1'b0, 1'b0, 1'b1},
      {16'hAAAA, 16'h5555, 1'b0, 16'hFFFF, 1'b0, 1'b0, 1'b1},
      {16'hAAAA, 16'h5555, 1'b1, 16'h0000, 1'b1, 1'b0, 1'b1},  // R6
      {16'hFFFF, 16'h0001, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0},
      {16'hFFFF, 16'hFFFF, 1'b1, 16'hFFFF, 1'b1, 1'b1, 1'b0},
      {16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0},
      {16'h000F, 16'h0001, 1'b0, 16'h0010, 1'b0, 1'b0, 1'b0},  // R7
      {16'h00FF, 16'h0001, 1'b0, 16'h0100, 1'b0, 1'b0, 1'b0},  // R7
      {16'h0FFF, 16'h0001, 1'b0, 16'h1000, 1'b0, 1'b0, 1'b0},  // R7
      {16'h8000, 16'h8000, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0},
      {16'h1234, 16'h4321, 1'b1, 16'h5556, 1'b0, 1'b0, 1'b0},
      {16'hFFFF, 16'h0000, 1'b1, 16'h0000, 1'b1, 1'b0, 1'b1}   // R6
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h (a=%h b=%h cin=%b)",
                  req, act, exp, opa, opb, carry_in);
      end
   endtask

   task automatic apply(input logic [15:0] a, input logic [15:0] b, input logic ci);
      @(posedge clk);
      opa = a; opb = b; carry_in = ci;
      @(negedge clk);
   endtask

   task automatic check_all();
      logic [16:0] full, nocin;
      full  = {1'b0, opa} + {1'b0, opb} + {16'b0, carry_in};
      nocin = {1'b0, opa} + {1'b0, opb};
      chk("R1", {16'b0, sum}, {16'b0, full[15:0]});
      chk("R2", {31'b0, carry_out}, {31'b0, full[16]});
      chk("R3", {31'b0, blk_gen}, {31'b0, nocin[16]});
      chk("R4", {31'b0, blk_prop}, {31'b0, ((opa ^ opb) == 16'hFFFF)});
      chk("R5", {31'b0, carry_out}, {31'b0, blk_gen | (blk_prop & carry_in)});
      chk("R8", {31'b0, blk_gen & blk_prop}, 32'd0);
   endtask

   initial begin
      #500000;
      if (!done) begin
         nfail++; nchk++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", nchk - nfail, nchk);
         $finish;
      end
   end

   initial begin
      opa = '0; opb = '0; carry_in = 1'b0;
      // idle state: all-zero inputs give all-zero outputs (R1, R2)
      @(negedge clk);
      chk("R1", {16'b0, sum}, 32'd0);
      chk("R2", {29'b0, carry_out, blk_gen, blk_prop}, 32'd0);

      // table walk: hand-worked expected results
      for (int i = 0; i < NV; i++) begin
         apply(VECS[i][51:36], VECS[i][35:20], VECS[i][19]);
         chk("R1", {16'b0, sum}, {16'b0, VECS[i][18:3]});
         chk("R2", {31'b0, carry_out}, {31'b0, VECS[i][2]});
         chk("R3", {31'b0, blk_gen}, {31'b0, VECS[i][1]});
         chk("R4", {31'b0, blk_prop}, {31'b0, VECS[i][0]});
      end

      // R6: full propagate with carry-in, carry crosses all groups
      apply(16'h5A5A, 16'hA5A5, 1'b1);
      chk("R6", {15'b0, carry_out, sum}, 32'h0001_0000);
      // same operands without carry-in: no carry-out, generate stays low (R3)
      apply(16'h5A5A, 16'hA5A5, 1'b0);
      chk("R6", {15'b0, carry_out, sum}, 32'h0000_FFFF);
      chk("R3", {31'b0, blk_gen}, 32'd0);

      // R7: carry born in each group boundary reaches the next group
      for (int k = 0; k < 3; k++) begin
         apply(16'((32'h1 << (4 * (k + 1))) - 1), 16'h0001, 1'b0);
         chk("R7", {16'b0, sum}, 32'h1 << (4 * (k + 1)));
      end

      // random operands against the behavioural sum
      for (int n = 0; n < 400; n++) begin
         apply(16'($urandom), 16'($urandom), 1'($urandom));
         check_all();
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end
endmodule